// File: doc/BRIEF.md
# Processor-facing status and control register bank

This block sits behind a microcontroller bus front end and in front of application logic. The front end has already decoded the bus cycle into a one-cycle write strobe or read strobe, a two-bit register select and a write byte. The bank holds four byte-wide registers: status, control, data-in and data-out. It turns bus accesses and application events into flag updates, control fields, a start pulse and an active-low interrupt request. The data-in byte is passed straight to the application. The data-out byte is loaded by the application and can only be read by the processor.

The status flags do not all clear in the same way. Error and pending-interrupt flags stay set until software writes a zero to their bit. The need-data flag clears when the data-in register is written. The data-ready flag clears when the data-out register is read. Software controls the application through three control bits: an enable, an interrupt enable and a start bit that fires on a rising edge. The other control bits are passed through as plain fields.

Top module: `mcu_regbank`

## Requirements
- R1: Reset clears every register and output state. The exception is the need-data flag, which comes out of reset set. After reset the status register reads 0x10, the other three registers read 0x00, int_n is 1, app_rst is 1 and start_pulse is 0.
- R2: Status bit 7 is read-only. It shows the level of ev_done sampled at the previous clock edge.
- R3: Status bit 6 (error) is set by ev_error, and status bit 5 (interrupt pending) is set by ev_irq. A status write clears a flag only where the written bit is 0, and writing 1 has no effect. If an event and a clearing write land in the same cycle, the flag stays set.
- R4: Status bit 4 (need data) is set out of reset and in the cycle after a start pulse. A write to the data-in register clears it, and that write takes priority over a same-cycle set.
- R5: Status bit 3 (data ready) is set by ld_out. A read strobe on the data-out register clears it. If a load and that read happen in the same cycle, the flag ends up set.
- R6: Status bits 2 to 0 always read 0, even after a write of ones.
- R7: Control bit 7 enables the application, and app_rst equals its inverse. While bit 7 is 0, ctl_bits reads 0. While bit 7 is 1, ctl_bits carries control bits 4 to 0. The control register itself always reads back the byte that was written.
- R8: int_n is 0 exactly when control bits 7 and 6 are both 1 and at least one of status bits 6, 5, 4 or 3 is set. Clearing bit 6 raises int_n but leaves every status flag unchanged.
- R9: start_pulse is 1 for exactly one clock, in the cycle after a control write that sets bit 5 when the old bit 5 was 0 and the written bit 7 is 1. No other write produces it.
- R10: Select codes are 0 for status, 1 for control, 2 for data-in and 3 for data-out. rdata shows the selected register combinationally. Data-in is read/write and appears on din_byte. Bus writes to data-out are ignored, and ld_out loads it with ld_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write strobe from the bus front end |
| rd_en | input | 1 | One-cycle read strobe from the bus front end |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write byte |
| ev_done | input | 1 | Application operation-complete level |
| ev_error | input | 1 | Application error event, sets the error flag |
| ev_irq | input | 1 | Application interrupt event, sets the pending flag |
| ld_out | input | 1 | Load strobe for the data-out register |
| ld_byte | input | 8 | Byte loaded into data-out |
| rdata | output | 8 | Read value of the selected register |
| ctl_bits | output | 5 | Plain control field, zero while disabled |
| app_rst | output | 1 | Holds the application in reset while the enable bit is 0 |
| start_pulse | output | 1 | One-clock start request |
| din_byte | output | 8 | Data-in register contents |
| int_n | output | 1 | Active-low interrupt request |

## Verification
The bench puts a flag event and a clearing access in the same cycle. A design with the wrong priority would lose an error or a freshly loaded byte in that case. It writes ones to the status register to catch a design that clears flags on any write, or that lets the unused low bits take the written value. It toggles the interrupt enable while causes are pending and checks that the flags survive, because a design could otherwise lose interrupts by clearing them on mask. It also rewrites an already-set start bit and raises the start bit while the application is disabled, where a level-triggered or ungated start would fire a spurious pulse.

// File: rtl/rb_pkg.sv
package rb_pkg;
    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DIN  = 2'd2,
        SEL_DOUT = 2'd3
    } rb_sel_e;
endpackage

// File: rtl/rb_status_flags.sv
module rb_status_flags (
    input  logic clk,
    input  logic rst,
    input  logic ev_done,
    input  logic ev_error,
    input  logic ev_irq,
    input  logic ld_out,
    input  logic start_pls,
    input  logic wr_stat,
    input  logic keep_err,
    input  logic keep_ip,
    input  logic wr_din,
    input  logic rd_dout,
    output logic done_o,
    output logic err_o,
    output logic ipend_o,
    output logic ndata_o,
    output logic drdy_o
);
    typedef struct packed {
        logic done;
        logic err;
        logic ipend;
        logic ndata;
        logic drdy;
    } flags_t;

    localparam flags_t RST_VAL = '{done: 1'b0, err: 1'b0, ipend: 1'b0, ndata: 1'b1, drdy: 1'b0};

    flags_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = ev_done;
        if (wr_stat && !keep_err) st_d.err = 1'b0;
        if (ev_error)             st_d.err = 1'b1;
        if (wr_stat && !keep_ip)  st_d.ipend = 1'b0;
        if (ev_irq)               st_d.ipend = 1'b1;
        if (start_pls)            st_d.ndata = 1'b1;
        if (wr_din)               st_d.ndata = 1'b0;
        if (rd_dout)              st_d.drdy = 1'b0;
        if (ld_out)               st_d.drdy = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_VAL;
        else     st_q <= st_d;
    end

    assign done_o  = st_q.done;
    assign err_o   = st_q.err;
    assign ipend_o = st_q.ipend;
    assign ndata_o = st_q.ndata;
    assign drdy_o  = st_q.drdy;
endmodule

// File: rtl/rb_control.sv
module rb_control #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              start_o
);
    localparam int EN_BIT = DATA_W - 1;
    localparam int GO_BIT = DATA_W - 3;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              start;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.start = 1'b0;
        if (wr_ctrl) begin
            c_d.ctrl  = wdata;
            c_d.start = wdata[EN_BIT] && wdata[GO_BIT] && !c_q.ctrl[GO_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign ctrl_o  = c_q.ctrl;
    assign start_o = c_q.start;
endmodule

// File: rtl/rb_data_regs.sv
module rb_data_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_din,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ld_out,
    input  logic [DATA_W-1:0] ld_byte,
    output logic [DATA_W-1:0] din_o,
    output logic [DATA_W-1:0] dout_o
);
    typedef struct packed {
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] dout;
    } dat_t;

    dat_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_din) r_d.din  = wdata;
        if (ld_out) r_d.dout = ld_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign din_o  = r_q.din;
    assign dout_o = r_q.dout;
endmodule

// File: rtl/mcu_regbank.sv
module mcu_regbank #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ev_done,
    input  logic              ev_error,
    input  logic              ev_irq,
    input  logic              ld_out,
    input  logic [DATA_W-1:0] ld_byte,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-4:0] ctl_bits,
    output logic              app_rst,
    output logic              start_pulse,
    output logic [DATA_W-1:0] din_byte,
    output logic              int_n
);
    import rb_pkg::*;

    localparam int CTL_W  = DATA_W - 3;
    localparam int PAD_W  = DATA_W - 5;
    localparam int EN_BIT = DATA_W - 1;
    localparam int IE_BIT = DATA_W - 2;

    logic              wr_stat, wr_ctrl, wr_din, rd_dout;
    logic              stat_done, stat_err, stat_ip, stat_nd, stat_dr;
    logic [DATA_W-1:0] ctrl_q, din_q, dout_q, stat_word;

    assign wr_stat = wr_en && (addr == SEL_STAT);
    assign wr_ctrl = wr_en && (addr == SEL_CTRL);
    assign wr_din  = wr_en && (addr == SEL_DIN);
    assign rd_dout = rd_en && (addr == SEL_DOUT);

    rb_status_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ev_done  (ev_done),
        .ev_error (ev_error),
        .ev_irq   (ev_irq),
        .ld_out   (ld_out),
        .start_pls(start_pulse),
        .wr_stat  (wr_stat),
        .keep_err (wdata[DATA_W-2]),
        .keep_ip  (wdata[DATA_W-3]),
        .wr_din   (wr_din),
        .rd_dout  (rd_dout),
        .done_o   (stat_done),
        .err_o    (stat_err),
        .ipend_o  (stat_ip),
        .ndata_o  (stat_nd),
        .drdy_o   (stat_dr)
    );

    rb_control #(.DATA_W(DATA_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_ctrl(wr_ctrl),
        .wdata  (wdata),
        .ctrl_o (ctrl_q),
        .start_o(start_pulse)
    );

    rb_data_regs #(.DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .rst    (rst),
        .wr_din (wr_din),
        .wdata  (wdata),
        .ld_out (ld_out),
        .ld_byte(ld_byte),
        .din_o  (din_q),
        .dout_o (dout_q)
    );

    assign stat_word = {stat_done, stat_err, stat_ip, stat_nd, stat_dr, {PAD_W{1'b0}}};

    always_comb begin
        case (rb_sel_e'(addr))
            SEL_STAT: rdata = stat_word;
            SEL_CTRL: rdata = ctrl_q;
            SEL_DIN:  rdata = din_q;
            default:  rdata = dout_q;
        endcase
    end

    assign app_rst  = !ctrl_q[EN_BIT];
    assign ctl_bits = ctrl_q[EN_BIT] ? ctrl_q[CTL_W-1:0] : '0;
    assign din_byte = din_q;
    assign int_n    = !(ctrl_q[EN_BIT] && ctrl_q[IE_BIT] &&
                        (stat_err || stat_ip || stat_nd || stat_dr));
endmodule

// File: rtl/rb_chk.sv
module rb_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic              ld_out,
    input logic              start_pulse,
    input logic              app_rst,
    input logic              int_n,
    input logic              stat_err,
    input logic              stat_nd,
    input logic              stat_dr
);
    import rb_pkg::*;

    // R3
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_err && !(wr_en && addr == SEL_STAT && !wdata[DATA_W-2])) |=> stat_err);

    // R4
    nd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_DIN) |=> !stat_nd);

    // R5
    dr_set_chk: assert property (@(posedge clk) disable iff (rst)
        ld_out |=> stat_dr);

    // R5
    dr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == SEL_DOUT && !ld_out) |=> !stat_dr);

    // R9
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R9
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(wr_en && addr == SEL_CTRL && wdata[DATA_W-1]));

    // R8
    int_gate_chk: assert property (@(posedge clk) disable iff (rst)
        app_rst |-> int_n);
endmodule

bind mcu_regbank rb_chk #(.DATA_W(DATA_W)) i_rb_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .ld_out     (ld_out),
    .start_pulse(start_pulse),
    .app_rst    (app_rst),
    .int_n      (int_n),
    .stat_err   (stat_err),
    .stat_nd    (stat_nd),
    .stat_dr    (stat_dr)
);

// File: tb/test_mcu_regbank.sv
`timescale 1ns/100ps
module test_mcu_regbank;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en, ev_done, ev_error, ev_irq, ld_out;
    logic [1:0] addr;
    logic [7:0] wdata, ld_byte, rdata, din_byte;
    logic [4:0] ctl_bits;
    logic       app_rst, start_pulse, int_n;

    int n_chk  = 0;
    int n_fail = 0;

    mcu_regbank i_mcu_regbank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .ev_done(ev_done), .ev_error(ev_error), .ev_irq(ev_irq),
        .ld_out(ld_out), .ld_byte(ld_byte), .rdata(rdata), .ctl_bits(ctl_bits),
        .app_rst(app_rst), .start_pulse(start_pulse), .din_byte(din_byte),
        .int_n(int_n)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [1:0] a;
        logic [7:0] wd;
        logic       er;
        logic       iq;
        logic       ld;
        logic [7:0] lb;
        logic       dn;
        logic [1:0] ca;
        logic [7:0] ex;
        logic       ei;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    // select codes: 0 status, 1 control, 2 data-in, 3 data-out
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,2'd1,8'hC0,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h10,1'b0,4'd8},  // R8 enable, need-data pending
        '{1'b1,1'b0,2'd2,8'h5A,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h00,1'b1,4'd4},  // R4 din write clears need-data
        '{1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,2'd2,8'h5A,1'b1,4'd10}, // R10 din readback
        '{1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,1'b0,8'h00,1'b0,2'd0,8'h40,1'b0,4'd3},  // R3 error set
        '{1'b1,1'b0,2'd0,8'hFF,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h40,1'b0,4'd3},  // R3 writing ones keeps
        '{1'b1,1'b0,2'd0,8'hBF,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h00,1'b1,4'd3},  // R3 write zero clears
        '{1'b1,1'b0,2'd0,8'h00,1'b1,1'b0,1'b0,8'h00,1'b0,2'd0,8'h40,1'b0,4'd3},  // R3 set beats clear
        '{1'b1,1'b0,2'd0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h00,1'b1,4'd3},  // R3
        '{1'b0,1'b0,2'd0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b0,2'd0,8'h20,1'b0,4'd3},  // R3 pending set
        '{1'b1,1'b0,2'd1,8'h80,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h20,1'b1,4'd8},  // R8 mask keeps flag
        '{1'b1,1'b0,2'd1,8'hC0,1'b0,1'b0,1'b0,8'h00,1'b0,2'd1,8'hC0,1'b0,4'd8},  // R8 unmask
        '{1'b1,1'b0,2'd0,8'hDF,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h00,1'b1,4'd3},  // R3 clear pending
        '{1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,1'b1,8'h3C,1'b0,2'd0,8'h08,1'b0,4'd5},  // R5 load sets ready
        '{1'b1,1'b0,2'd3,8'h11,1'b0,1'b0,1'b0,8'h00,1'b0,2'd3,8'h3C,1'b0,4'd10}, // R10 dout write ignored
        '{1'b0,1'b1,2'd3,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h00,1'b1,4'd5},  // R5 read clears ready
        '{1'b0,1'b1,2'd3,8'h00,1'b0,1'b0,1'b1,8'h99,1'b0,2'd0,8'h08,1'b0,4'd5},  // R5 load beats read
        '{1'b0,1'b1,2'd3,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h00,1'b1,4'd5},  // R5
        '{1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,2'd3,8'h99,1'b1,4'd10}, // R10 dout loaded
        '{1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b1,2'd0,8'h80,1'b1,4'd2},  // R2 done follows
        '{1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h00,1'b1,4'd2},  // R2
        '{1'b1,1'b0,2'd0,8'h07,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,8'h00,1'b1,4'd6},  // R6 low bits read 0
        '{1'b1,1'b0,2'd2,8'hA5,1'b0,1'b0,1'b0,8'h00,1'b0,2'd2,8'hA5,1'b1,4'd10}  // R10
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; ev_done = 0; ev_error = 0; ev_irq = 0;
        ld_out = 0; wdata = 8'h00; ld_byte = 8'h00;
    endtask

    // drive one write this cycle, then settle away from the edge
    task automatic wr_cycle(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk); idle(); #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    task automatic check_reset_state();
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a); #0.2;
            chk(rdata, (a == 0) ? 8'h10 : 8'h00, 1, "reset register value");  // R1
        end
        chk({7'd0, int_n}, 8'h01, 1, "reset int_n");
        chk({7'd0, app_rst}, 8'h01, 1, "reset app_rst");
        chk({7'd0, start_pulse}, 8'h00, 1, "reset start_pulse");
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; addr = 0; idle();
        repeat (3) @(negedge clk);
        rst = 0; #1;
        check_reset_state();  // R1

        for (int i = 0; i < NV; i++) begin
            wr_en = VECS[i].wr; rd_en = VECS[i].rd; addr = VECS[i].a;
            wdata = VECS[i].wd; ev_error = VECS[i].er; ev_irq = VECS[i].iq;
            ld_out = VECS[i].ld; ld_byte = VECS[i].lb; ev_done = VECS[i].dn;
            @(negedge clk); idle();
            addr = VECS[i].ca; #1;
            chk(rdata, VECS[i].ex, int'(VECS[i].req), $sformatf("vector %0d rdata", i));
            chk({7'd0, int_n}, {7'd0, VECS[i].ei}, 8, $sformatf("vector %0d int_n", i));
        end

        // R9 rising start bit with enable gives one pulse, then R4 need-data refills
        wr_cycle(2'd1, 8'hE0);
        chk({7'd0, start_pulse}, 8'h01, 9, "start after 0->1");
        chk({3'd0, ctl_bits}, 8'h00, 7, "ctl_bits after E0");
        @(negedge clk); #1;
        chk({7'd0, start_pulse}, 8'h00, 9, "start lasts one clock");
        addr = 2'd0; #0.2;
        chk(rdata, 8'h10, 4, "need-data set after start");
        chk({7'd0, int_n}, 8'h00, 8, "int from need-data");

        // R9 rewriting an already-set start bit gives no pulse
        wr_cycle(2'd1, 8'hE5);
        chk({7'd0, start_pulse}, 8'h00, 9, "no start on rewrite");
        chk({3'd0, ctl_bits}, 8'h05, 7, "ctl_bits pass-through");

        // R7 disabled: fields gated, application held in reset
        wr_cycle(2'd1, 8'h3F);
        chk({7'd0, app_rst}, 8'h01, 7, "app_rst while disabled");
        chk({3'd0, ctl_bits}, 8'h00, 7, "ctl_bits gated while disabled");
        chk({7'd0, int_n}, 8'h01, 8, "int masked while disabled");
        addr = 2'd1; #0.2;
        chk(rdata, 8'h3F, 7, "control readback while disabled");

        // R9 raising start while disabled gives no pulse
        wr_cycle(2'd1, 8'h00);
        wr_cycle(2'd1, 8'h20);
        chk({7'd0, start_pulse}, 8'h00, 9, "no start while disabled");
        wr_cycle(2'd1, 8'h00);
        wr_cycle(2'd1, 8'hA3);
        chk({7'd0, start_pulse}, 8'h01, 9, "start with enable in same write");
        chk({7'd0, app_rst}, 8'h00, 7, "app_rst released");
        chk({3'd0, ctl_bits}, 8'h03, 7, "ctl_bits when enabled");
        chk(din_byte, 8'hA5, 10, "din_byte output");

        // R1 reset in mid-run
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0; #1;
        check_reset_state();

        finish_run();
    end
endmodule